// File: doc/BRIEF.md
# Dual-Processor Shared RAM Access Controller

This controller stands between four requesters (a CPU and a DMA engine in each of two processor subsystems) and a bank of shared RAM blocks. Each block has an owner bit that assigns it to subsystem 1 or subsystem 2. Each fetch, read or write request is checked against that owner bit and against two protection bits for the block. A permitted request goes straight on to the RAM side. A refused request is consumed at once, never reaches the RAM, and raises a one-cycle violation pulse that reports the requester and the block.

A small configuration port holds the owner bits, the protection bits, per-block lock bits and per-block commit bits. Only writes from processor 1 may change ownership. Processor 2 can only read ownership back. A lock can be set and cleared again. A commit bit can only be set, and it freezes the whole configuration of its block until reset.

The request side is valid/ready. A permitted request completes when `ram_valid` and `ram_ready` are both high, and `req_ready` follows `ram_ready`. A refused request sees `req_ready` high in the same cycle, so it can never stall the requester. The request fields pass through without registering, and the RAM side must hold `ram_ready` independent of `ram_valid`.

Top module: `sram_share_ctrl`

## Requirements
- R1: After reset, all owner bits are 0 (every block belongs to subsystem 1). Protection, lock and commit bits are all 0, and `viol_valid` is low.
- R2: Port IDs are 0=CPU1, 1=DMA1, 2=CPU2, 3=DMA2. Kind codes are 0=fetch, 1=read, 2=write, 3=reserved. A block is owned by subsystem 1 when its owner bit is 0 and by subsystem 2 when it is 1. With protection clear, the owner's CPU may fetch, read and write the block, and the owner's DMA may read and write it.
- R3: The non-owning CPU and the non-owning DMA may only read the block. A DMA fetch is refused for every block, and so is the reserved kind 3.
- R4: When a block's fetch-protect bit is set, the owner CPU's fetch of that block is refused. When its DMA-write-protect bit is set, the owner DMA's write to that block is refused.
- R5: A refused request never drives `ram_valid`, and `req_ready` is high in that cycle. In the next cycle `viol_valid` is high for exactly one cycle, with `viol_port` and `viol_blk` equal to the refused request's fields.
- R6: A permitted request appears on the RAM side in the same cycle with its port, block and kind unchanged, and `req_ready` equals `ram_ready`.
- R7: A configuration write to the owner register (address 0) with `cfg_src`=1 (processor 2) changes no owner bit.
- R8: Register 3 holds the owner-lock bits and register 4 the protection-lock bits. While a block's owner-lock bit is set, writes to its owner bit are ignored. While its protection-lock bit is set, writes to its two protection bits are ignored. Lock bits can be cleared by writing 0.
- R9: Register 5 holds the commit bits. Writing 1 sets a commit bit and writing 0 has no effect. While a block's commit bit is set, its owner, protection and lock bits ignore all writes. Only reset clears a commit bit.
- R10: `cfg_rdata` shows, without a clock delay, the register chosen by `cfg_raddr`. The map is 0 owner, 1 fetch-protect, 2 DMA-write-protect, 3 owner-lock, 4 protection-lock, 5 commit, and 6 and 7 read as 0. Bit i of each register belongs to block i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_port | input | 2 | Requester ID |
| req_blk | input | BW | Target block index |
| req_kind | input | 2 | Access kind |
| ram_valid | output | 1 | Permitted request toward RAM |
| ram_ready | input | 1 | RAM side accepts |
| ram_port | output | 2 | Requester ID toward RAM |
| ram_blk | output | BW | Block index toward RAM |
| ram_kind | output | 2 | Access kind toward RAM |
| viol_valid | output | 1 | One-cycle refusal pulse |
| viol_port | output | 2 | Requester of the refused access |
| viol_blk | output | BW | Block of the refused access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 1 | Writing processor: 0 = processor 1, 1 = processor 2 |
| cfg_waddr | input | 3 | Write register address |
| cfg_wdata | input | NBLK | Write data, one bit per block |
| cfg_raddr | input | 3 | Read register address |
| cfg_rdata | output | NBLK | Read data |

## Verification
The hardest condition to reach is a committed block that is then hit, in later cycles, by owner, protection and lock writes and by a clearing write to the commit register, while other blocks stay open to change. Meeting it needs a full configuration sequence before the attack. The stimulus therefore sets ownership, sets locks, commits two blocks, writes inverted patterns to every register, and sweeps every port, kind and block against the reference model. A second reset then checks that the freeze is released.

// File: rtl/sram_share_pkg.sv
package sram_share_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  localparam logic [2:0] REG_OWNER    = 3'd0;
  localparam logic [2:0] REG_NOFETCH  = 3'd1;
  localparam logic [2:0] REG_NODMAW   = 3'd2;
  localparam logic [2:0] REG_LOCKOWN  = 3'd3;
  localparam logic [2:0] REG_LOCKPROT = 3'd4;
  localparam logic [2:0] REG_COMMIT   = 3'd5;
endpackage

// File: rtl/sram_cfg_regs.sv
module sram_cfg_regs #(
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            src,
  input  logic [2:0]      waddr,
  input  logic [NBLK-1:0] wdata,
  input  logic [2:0]      raddr,
  output logic [NBLK-1:0] rdata,
  output logic [NBLK-1:0] owner_q,
  output logic [NBLK-1:0] nofetch_q,
  output logic [NBLK-1:0] nodmaw_q,
  output logic [NBLK-1:0] lockown_q,
  output logic [NBLK-1:0] lockprot_q,
  output logic [NBLK-1:0] commit_q
);
  import sram_share_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q    <= '0;
      nofetch_q  <= '0;
      nodmaw_q   <= '0;
      lockown_q  <= '0;
      lockprot_q <= '0;
      commit_q   <= '0;
    end else if (we) begin
      for (int i = 0; i < NBLK; i++) begin
        if (!commit_q[i]) begin
          case (waddr)
            REG_OWNER:    if (!src && !lockown_q[i]) owner_q[i] <= wdata[i];
            REG_NOFETCH:  if (!lockprot_q[i]) nofetch_q[i] <= wdata[i];
            REG_NODMAW:   if (!lockprot_q[i]) nodmaw_q[i] <= wdata[i];
            REG_LOCKOWN:  lockown_q[i] <= wdata[i];
            REG_LOCKPROT: lockprot_q[i] <= wdata[i];
            default: ;
          endcase
        end
        if (waddr == REG_COMMIT && wdata[i]) commit_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (raddr)
      REG_OWNER:    rdata = owner_q;
      REG_NOFETCH:  rdata = nofetch_q;
      REG_NODMAW:   rdata = nodmaw_q;
      REG_LOCKOWN:  rdata = lockown_q;
      REG_LOCKPROT: rdata = lockprot_q;
      REG_COMMIT:   rdata = commit_q;
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/sram_perm_check.sv
module sram_perm_check #(
  parameter int NBLK = 8,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic [1:0]      port,
  input  logic [BW-1:0]   blk,
  input  logic [1:0]      kind,
  input  logic [NBLK-1:0] owner,
  input  logic [NBLK-1:0] nofetch,
  input  logic [NBLK-1:0] nodmaw,
  output logic            allow
);
  import sram_share_pkg::*;

  logic in_range, is_dma, mine;

  assign in_range = (32'(blk) < NBLK);
  assign is_dma   = port[0];
  assign mine     = in_range && (owner[blk] == port[1]);

  always_comb begin
    allow = 1'b0;
    if (in_range) begin
      case (acc_kind_e'(kind))
        KIND_FETCH: allow = mine && !is_dma && !nofetch[blk];
        KIND_READ:  allow = 1'b1;
        KIND_WRITE: allow = mine && (!is_dma || !nodmaw[blk]);
        default:    allow = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sram_viol_track.sv
module sram_viol_track #(
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deny,
  input  logic [1:0]    port,
  input  logic [BW-1:0] blk,
  output logic          viol_valid,
  output logic [1:0]    viol_port,
  output logic [BW-1:0] viol_blk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_port  <= '0;
      viol_blk   <= '0;
    end else begin
      viol_valid <= deny;
      if (deny) begin
        viol_port <= port;
        viol_blk  <= blk;
      end
    end
  end
endmodule

// File: rtl/sram_share_ctrl.sv
module sram_share_ctrl #(
  parameter int NBLK = 8,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_port,
  input  logic [BW-1:0]   req_blk,
  input  logic [1:0]      req_kind,
  output logic            ram_valid,
  input  logic            ram_ready,
  output logic [1:0]      ram_port,
  output logic [BW-1:0]   ram_blk,
  output logic [1:0]      ram_kind,
  output logic            viol_valid,
  output logic [1:0]      viol_port,
  output logic [BW-1:0]   viol_blk,
  input  logic            cfg_we,
  input  logic            cfg_src,
  input  logic [2:0]      cfg_waddr,
  input  logic [NBLK-1:0] cfg_wdata,
  input  logic [2:0]      cfg_raddr,
  output logic [NBLK-1:0] cfg_rdata
);
  logic [NBLK-1:0] owner_q, nofetch_q, nodmaw_q, lockown_q, lockprot_q, commit_q;
  logic allow, deny;

  sram_cfg_regs #(.NBLK(NBLK)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .src(cfg_src),
    .waddr(cfg_waddr), .wdata(cfg_wdata), .raddr(cfg_raddr), .rdata(cfg_rdata),
    .owner_q(owner_q), .nofetch_q(nofetch_q), .nodmaw_q(nodmaw_q),
    .lockown_q(lockown_q), .lockprot_q(lockprot_q), .commit_q(commit_q)
  );

  sram_perm_check #(.NBLK(NBLK)) u_perm (
    .port(req_port), .blk(req_blk), .kind(req_kind),
    .owner(owner_q), .nofetch(nofetch_q), .nodmaw(nodmaw_q), .allow(allow)
  );

  assign deny      = req_valid && !allow;
  assign ram_valid = req_valid && allow;
  assign req_ready = allow ? ram_ready : 1'b1;
  assign ram_port  = req_port;
  assign ram_blk   = req_blk;
  assign ram_kind  = req_kind;

  sram_viol_track #(.BW(BW)) u_viol (
    .clk(clk), .rst_n(rst_n), .deny(deny), .port(req_port), .blk(req_blk),
    .viol_valid(viol_valid), .viol_port(viol_port), .viol_blk(viol_blk)
  );
endmodule

// File: rtl/sram_share_chk.sv
module sram_share_chk #(
  parameter int NBLK = 8,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_port,
  input logic [BW-1:0]   req_blk,
  input logic            ram_valid,
  input logic [1:0]      ram_port,
  input logic [BW-1:0]   ram_blk,
  input logic [1:0]      ram_kind,
  input logic            viol_valid,
  input logic [1:0]      viol_port,
  input logic [BW-1:0]   viol_blk,
  input logic            cfg_we,
  input logic            cfg_src,
  input logic [2:0]      cfg_waddr,
  input logic [NBLK-1:0] owner_q,
  input logic [NBLK-1:0] nofetch_q,
  input logic [NBLK-1:0] nodmaw_q,
  input logic [NBLK-1:0] lockown_q,
  input logic [NBLK-1:0] lockprot_q,
  input logic [NBLK-1:0] commit_q
);
  // R3
  nonowner_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid && ram_kind == 2'd2) |-> (owner_q[ram_blk] == ram_port[1]));

  // R5
  deny_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ram_valid) |-> req_ready);

  // R5
  viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ram_valid) |=> (viol_valid && viol_port == $past(req_port)
                                   && viol_blk == $past(req_blk)));

  // R5
  viol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !ram_valid) |=> !viol_valid);

  // R7
  cpu2_owner_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_src && cfg_waddr == 3'd0) |=> $stable(owner_q));

  // R9
  commit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((commit_q & $past(commit_q)) == $past(commit_q)));

  // R9
  commit_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(commit_q) & ((owner_q ^ $past(owner_q)) | (nofetch_q ^ $past(nofetch_q))
      | (nodmaw_q ^ $past(nodmaw_q)) | (lockown_q ^ $past(lockown_q))
      | (lockprot_q ^ $past(lockprot_q)))) == '0));

  // R8
  owner_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lockown_q) & (owner_q ^ $past(owner_q))) == '0));
endmodule

bind sram_share_ctrl sram_share_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_port(req_port), .req_blk(req_blk), .ram_valid(ram_valid),
  .ram_port(ram_port), .ram_blk(ram_blk), .ram_kind(ram_kind),
  .viol_valid(viol_valid), .viol_port(viol_port), .viol_blk(viol_blk),
  .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_waddr(cfg_waddr),
  .owner_q(owner_q), .nofetch_q(nofetch_q), .nodmaw_q(nodmaw_q),
  .lockown_q(lockown_q), .lockprot_q(lockprot_q), .commit_q(commit_q)
);

// File: tb/sim_sram_share_ctrl.sv
module sim_sram_share_ctrl;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       req_valid = 0, ram_ready = 0, cfg_we = 0, cfg_src = 0;
  logic [1:0] req_port = 0, req_kind = 0;
  logic [2:0] req_blk = 0, cfg_waddr = 0, cfg_raddr = 0;
  logic [7:0] cfg_wdata = 0;
  wire        req_ready, ram_valid, viol_valid;
  wire  [1:0] ram_port, ram_kind, viol_port;
  wire  [2:0] ram_blk, viol_blk;
  wire  [7:0] cfg_rdata;

  sram_share_ctrl #(.NBLK(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_blk(req_blk), .req_kind(req_kind),
    .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_port(ram_port),
    .ram_blk(ram_blk), .ram_kind(ram_kind), .viol_valid(viol_valid),
    .viol_port(viol_port), .viol_blk(viol_blk), .cfg_we(cfg_we),
    .cfg_src(cfg_src), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata)
  );

  // reference model state: one integer array per register
  int m_reg[6][NB];
  int m_viol, m_vport, m_vblk;
  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;
  logic [7:0] lfsr = 8'h5a;

  task automatic chk(string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got=%0h exp=%0h", cur_req, what, got, exp);
    end
  endtask

  function automatic int m_allow(int p, int b, int k);
    int mine = (m_reg[0][b] == ((p >= 2) ? 1 : 0));
    int dma  = (p == 1 || p == 3);
    if (k == 1) return 1;
    if (k == 0) return (mine && !dma && m_reg[1][b] == 0) ? 1 : 0;
    if (k == 2) return (mine && (!dma || m_reg[2][b] == 0)) ? 1 : 0;
    return 0;
  endfunction

  function automatic int m_read(int a);
    int v = 0;
    if (a > 5) return 0;
    for (int i = 0; i < NB; i++) v += m_reg[a][i] << i;
    return v;
  endfunction

  task automatic m_reset();
    for (int a = 0; a < 6; a++) for (int i = 0; i < NB; i++) m_reg[a][i] = 0;
    m_viol = 0; m_vport = 0; m_vblk = 0;
  endtask

  // inputs are set right after a negedge; compare, advance the model, return at next negedge
  task automatic tick();
    int al, nv, np, nb;
    int nreg[6][NB];
    #2;
    al = m_allow(req_port, req_blk, req_kind);
    chk("ram_valid", ram_valid, req_valid && al);
    chk("req_ready", req_ready, al ? ram_ready : 1);
    if (req_valid && al) begin
      chk("ram_fields", {ram_port, ram_blk, ram_kind}, {req_port, req_blk, req_kind});
    end
    chk("viol_valid", viol_valid, m_viol);
    if (m_viol) chk("viol_fields", {viol_port, viol_blk}, {m_vport[1:0], m_vblk[2:0]});
    chk("cfg_rdata", cfg_rdata, m_read(cfg_raddr));
    nv = req_valid && !al; np = m_vport; nb = m_vblk;
    if (nv) begin np = req_port; nb = req_blk; end
    nreg = m_reg;
    if (cfg_we) begin
      for (int i = 0; i < NB; i++) begin
        int d = cfg_wdata[i];
        if (m_reg[5][i] == 0) begin
          if (cfg_waddr == 0 && cfg_src == 0 && m_reg[3][i] == 0) nreg[0][i] = d;
          if ((cfg_waddr == 1 || cfg_waddr == 2) && m_reg[4][i] == 0) nreg[cfg_waddr][i] = d;
          if (cfg_waddr == 3 || cfg_waddr == 4) nreg[cfg_waddr][i] = d;
        end
        if (cfg_waddr == 5 && d == 1) nreg[5][i] = 1;
      end
    end
    @(posedge clk);
    m_reg = nreg; m_viol = nv; m_vport = np; m_vblk = nb;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    @(negedge clk);
  endtask

  task automatic wr(int src, int a, int d);
    cfg_we = 1; cfg_src = src[0]; cfg_waddr = a[2:0]; cfg_wdata = d[7:0];
    cfg_raddr = a[2:0];
    tick();
    cfg_we = 0;
    tick(); // readback of the same register
  endtask

  task automatic sweep(int use_bp);
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 4; k++) begin
          req_valid = 1; req_port = p[1:0]; req_blk = b[2:0]; req_kind = k[1:0];
          ram_ready = use_bp ? lfsr[0] : 1'b1;
          cfg_raddr = 3'((b + k) % 8);
          tick();
        end
    req_valid = 0;
    tick();
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    m_reset();
    do_reset();
    cur_req = "R1";
    for (int a = 0; a < 8; a++) begin cfg_raddr = a[2:0]; tick(); end
    cur_req = "R2";   sweep(0);
    cur_req = "R7";   wr(1, 0, 8'hff); wr(1, 0, 8'h3c);
    cur_req = "R10";  wr(0, 0, 8'ha5); wr(0, 6, 8'hff); cfg_raddr = 7; tick();
    cur_req = "R3";   sweep(0);
    cur_req = "R6";   sweep(1);
    cur_req = "R4";   wr(0, 1, 8'h0f); wr(0, 2, 8'hf0); wr(1, 1, 8'h3f); sweep(0);
    cur_req = "R5";
    for (int i = 0; i < 6; i++) begin
      req_valid = 1; req_port = 2'(i % 4); req_blk = 3'(i); req_kind = 2'd3; tick();
    end
    req_valid = 0; tick(); tick();
    cur_req = "R8";
    wr(0, 3, 8'h0f); wr(0, 0, 8'h5a); wr(0, 4, 8'hc3); wr(1, 1, 8'h00); wr(0, 2, 8'hff);
    wr(0, 3, 8'h00); wr(0, 0, 8'h5a); sweep(0);
    cur_req = "R9";
    wr(1, 5, 8'h03); wr(0, 5, 8'h00); wr(0, 3, 8'hff); wr(0, 3, 8'h00);
    wr(0, 0, 8'hff); wr(0, 1, 8'h00); wr(0, 2, 8'h00); wr(0, 4, 8'h00); sweep(0);
    do_reset();
    cfg_raddr = 5; tick(); cfg_raddr = 0; tick();
    wr(0, 0, 8'h01);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule